// File: doc/BRIEF.md
# Bus-Mapped Output Register

This block is an AHB-Lite slave with one 32-bit register whose value drives a parallel output port, for example a bank of LEDs. It follows the two-phase pipeline of the bus. Select, address, direction, transfer type and size are captured at the edge that ends the address phase, and only when `hready` is high. The write data is taken in the following cycle, the data phase, and is committed at the edge that ends that phase.

Writes can be byte, halfword or word wide. Only the byte lanes chosen by the size and by the low address bits are updated, using little-endian lane order. Reads return the register on `hrdata` during the data phase.

Valid transfers always complete with no wait states and an OKAY response. A transfer that the block cannot serve gets the two-cycle ERROR response and leaves the register untouched, provided `ERR_EN` is set. Such a transfer is one that addresses outside the single word, uses a size above a word, or is not aligned to its size.

Top module: `ahb_led_reg`

## Requirements
- R1: After reset `led_out` is 0, `hreadyout` is 1 and `hresp` is 0 (OKAY).
- R2: A NONSEQ (`htrans`=2'b10) or SEQ (2'b11) write to offset 0 with `hsize`=3'b010 (word) stores the `hwdata` of the next cycle. `hwdata` present during the address phase is not used. `led_out` shows the new value from the cycle after the data phase.
- R3: A byte write (`hsize`=3'b000) to offset n (`haddr[1:0]`=n) updates only bits [8n+7:8n], taken from the same bits of `hwdata`.
- R4: A halfword write (`hsize`=3'b001) with `haddr[1]`=h updates only bits [16h+15:16h].
- R5: IDLE (2'b00) and BUSY (2'b01) transfers cause no register access and get OKAY.
- R6: A transfer is not captured while `hsel` is low or while `hready` is low.
- R7: In the data phase of an accepted read, `hrdata` equals the register. In every other cycle `hrdata` is 0.
- R8: With `ERR_EN`=1, a transfer with `haddr[ADDR_W-1:2]` not zero gets ERROR for two cycles. In the first of these `hreadyout` is 0 and in the second it is 1. The register is unchanged.
- R9: With `ERR_EN`=1, a size above word (`hsize`>3'b010) or a misaligned access gets the same two-cycle ERROR and leaves the register unchanged. A halfword access is misaligned when `haddr[0]`=1, and a word access when `haddr[1:0]`≠0.
- R10: Valid transfers complete with no wait state: `hreadyout` is 1 and `hresp` is 0 in their data phase. `hreadyout` is low only in the first ERROR cycle.
- R11: With `ERR_EN`=0, unsupported transfers get OKAY with no wait and leave the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Active-low reset |
| hsel | input | 1 | Slave select |
| haddr | input | ADDR_W | Byte address within the slave window |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 = write, 0 = read |
| hsize | input | 3 | Access size |
| hready | input | 1 | Previous transfer complete on the bus |
| hwdata | input | 32 | Write data, valid in data phase |
| hrdata | output | 32 | Read data |
| hreadyout | output | 1 | Slave ready |
| hresp | output | 1 | 0 = OKAY, 1 = ERROR |
| led_out | output | 32 | Parallel output of the register |

## Verification
The bound checker watches, on every cycle, the shape of the ERROR response. It checks that a first cycle with `hreadyout` low is always followed by a second ERROR cycle with `hreadyout` high, and that `hreadyout` never drops without ERROR. It also checks that `hrdata` is non-zero only after a captured read, and that `led_out` changes only two edges after a captured write. Some properties depend on values: which byte lanes a given size and offset touch, that the write data comes from the data phase and not the address phase, that IDLE, BUSY, deselected and stalled transfers leave the register alone, and that the error-free variant answers OKAY. Only the directed scenarios in the bench can show these.

// File: rtl/ahb_led_reg.sv
module ahb_led_reg #(
  parameter int ADDR_W = 8,
  parameter bit ERR_EN = 1'b1
) (
  input  logic              hclk,
  input  logic              hresetn,
  input  logic              hsel,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic [2:0]        hsize,
  input  logic              hready,
  input  logic [31:0]       hwdata,
  output logic [31:0]       hrdata,
  output logic              hreadyout,
  output logic              hresp,
  output logic [31:0]       led_out
);

  localparam int LANES = 4;

  logic             accept, misalign, bad;
  logic [LANES-1:0] lanes;
  logic             dp_valid, dp_write;
  logic [LANES-1:0] dp_lanes;
  logic             err_first, err_second;
  logic [31:0]      reg_q;

  assign accept   = hsel & hready & htrans[1];
  assign misalign = ((hsize == 3'd1) & haddr[0]) | ((hsize == 3'd2) & (haddr[1:0] != 2'b00));
  assign bad      = (haddr[ADDR_W-1:2] != '0) | (hsize > 3'd2) | misalign;

  always_comb begin
    case (hsize)
      3'd0:    lanes = 4'b0001 << haddr[1:0];
      3'd1:    lanes = haddr[1] ? 4'b1100 : 4'b0011;
      default: lanes = 4'b1111;
    endcase
  end

  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn) begin
      dp_valid   <= 1'b0;
      dp_write   <= 1'b0;
      dp_lanes   <= '0;
      err_first  <= 1'b0;
      err_second <= 1'b0;
    end else begin
      if (hready) begin
        dp_valid <= accept & ~bad;
        dp_write <= hwrite;
        dp_lanes <= lanes;
      end
      err_first  <= ERR_EN && accept && bad;
      err_second <= err_first;
    end
  end

  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn) begin
      reg_q <= '0;
    end else if (dp_valid && dp_write) begin
      for (int i = 0; i < LANES; i++)
        if (dp_lanes[i]) reg_q[8*i +: 8] <= hwdata[8*i +: 8];
    end
  end

  assign hrdata    = (dp_valid && !dp_write) ? reg_q : '0;
  assign hresp     = err_first | err_second;
  assign hreadyout = ~err_first;
  assign led_out   = reg_q;

endmodule

// File: rtl/ahb_led_reg_chk.sv
module ahb_led_reg_chk #(
  parameter int ADDR_W = 8
) (
  input logic              hclk,
  input logic              hresetn,
  input logic              hsel,
  input logic [ADDR_W-1:0] haddr,
  input logic [1:0]        htrans,
  input logic              hwrite,
  input logic              hready,
  input logic [31:0]       hrdata,
  input logic              hreadyout,
  input logic              hresp,
  input logic [31:0]       led_out
);

  // R8
  err_second_cycle_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    (hresp && !hreadyout) |=> (hresp && hreadyout));

  // R8
  err_starts_stalled_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    $rose(hresp) |-> !hreadyout);

  // R10
  no_wait_when_okay_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    !hreadyout |-> hresp);

  // R7
  rdata_after_read_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    (hrdata != 32'd0) |-> $past(hsel && hready && htrans[1] && !hwrite));

  // R5
  led_change_from_write_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    (led_out != $past(led_out)) |-> ($past(hwrite, 2) && $past(hsel && hready && htrans[1], 2)));

endmodule

bind ahb_led_reg ahb_led_reg_chk #(.ADDR_W(ADDR_W)) u_chk (
  .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr), .htrans(htrans),
  .hwrite(hwrite), .hready(hready), .hrdata(hrdata), .hreadyout(hreadyout),
  .hresp(hresp), .led_out(led_out)
);

// File: tb/test_ahb_led_reg.sv
`timescale 1ns/1ps
module test_ahb_led_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hsel = 1'b0;
  logic [7:0]  haddr = '0;
  logic [1:0]  htrans = 2'b00;
  logic        hwrite = 1'b0;
  logic [2:0]  hsize = 3'd2;
  logic        stall = 1'b0;
  logic [31:0] hwdata = '0;
  logic [31:0] rdata_m, led_m, rdata_n, led_n;
  logic        rdy_m, resp_m, rdy_n, resp_n;
  logic        hready_m, hready_n;
  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  assign hready_m = rdy_m & ~stall;
  assign hready_n = rdy_n & ~stall;

  ahb_led_reg #(.ADDR_W(8), .ERR_EN(1'b1)) i_ahb_led_reg (
    .hclk(clk), .hresetn(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hsize(hsize), .hready(hready_m), .hwdata(hwdata),
    .hrdata(rdata_m), .hreadyout(rdy_m), .hresp(resp_m), .led_out(led_m));

  ahb_led_reg #(.ADDR_W(8), .ERR_EN(1'b0)) i_ahb_led_reg_noerr (
    .hclk(clk), .hresetn(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hsize(hsize), .hready(hready_n), .hwdata(hwdata),
    .hrdata(rdata_n), .hreadyout(rdy_n), .hresp(resp_n), .led_out(led_n));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic addr_phase(input logic s, input logic [7:0] a, input logic [1:0] t,
                            input logic w, input logic [2:0] sz);
    @(negedge clk);
    hsel = s; haddr = a; htrans = t; hwrite = w; hsize = sz; hwdata = 32'hDEAD_BEEF;
  endtask

  task automatic data_phase(input logic [31:0] wd);
    @(negedge clk);
    hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0; hwdata = wd;
  endtask

  task automatic t_write(input string req, input logic [7:0] a, input logic [2:0] sz,
                         input logic [1:0] t, input logic [31:0] wd, input logic [31:0] exp);
    addr_phase(1'b1, a, t, 1'b1, sz);
    data_phase(wd);
    chk("R10 ready", {31'd0, rdy_m}, 32'd1);
    chk("R10 okay", {31'd0, resp_m}, 32'd0);
    @(negedge clk);
    chk(req, led_m, exp);
  endtask

  task automatic t_read(input logic [31:0] exp);
    addr_phase(1'b1, 8'h00, 2'b10, 1'b0, 3'd2);
    data_phase(32'h0);
    chk("R7 read data", rdata_m, exp);
    @(negedge clk);
    chk("R7 idle rdata zero", rdata_m, 32'd0);
  endtask

  task automatic t_ignored(input string req, input logic s, input logic [1:0] t, input logic stl);
    logic [31:0] old;
    old = led_m;
    addr_phase(s, 8'h00, t, 1'b1, 3'd2);
    stall = stl;
    data_phase(32'h5A5A_5A5A);
    stall = 1'b0;
    chk({req, " okay"}, {31'd0, resp_m}, 32'd0);
    @(negedge clk);
    chk({req, " unchanged"}, led_m, old);
  endtask

  task automatic t_error(input string req, input logic [7:0] a, input logic [2:0] sz);
    logic [31:0] old, old_n;
    old = led_m; old_n = led_n;
    addr_phase(1'b1, a, 2'b10, 1'b1, sz);
    data_phase(32'hFFFF_FFFF);
    chk({req, " err1 resp"}, {31'd0, resp_m}, 32'd1);
    chk({req, " err1 ready"}, {31'd0, rdy_m}, 32'd0);
    chk("R11 okay", {30'd0, rdy_n, resp_n}, 32'd2);
    @(negedge clk);
    chk({req, " err2 resp"}, {31'd0, resp_m}, 32'd1);
    chk({req, " err2 ready"}, {31'd0, rdy_m}, 32'd1);
    @(negedge clk);
    chk({req, " after err"}, {30'd0, rdy_m, resp_m}, 32'd2);
    chk({req, " unchanged"}, led_m, old);
    chk("R11 unchanged", led_n, old_n);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #4_000_000;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    chk("R1 led", led_m, 32'd0);
    chk("R1 ready/resp", {30'd0, rdy_m, resp_m}, 32'd2);
    t_write("R2 word", 8'h00, 3'd2, 2'b10, 32'h1122_3344, 32'h1122_3344);
    t_read(32'h1122_3344);
    t_write("R3 byte2", 8'h02, 3'd0, 2'b10, 32'h00AA_0000, 32'h11AA_3344);
    t_write("R3 byte0", 8'h00, 3'd0, 2'b10, 32'hFFFF_FF77, 32'h11AA_3377);
    t_write("R3 byte3", 8'h03, 3'd0, 2'b11, 32'hC3FF_FFFF, 32'hC3AA_3377);
    t_write("R4 half1", 8'h02, 3'd1, 2'b10, 32'hBEEF_0000, 32'hBEEF_3377);
    t_write("R4 half0", 8'h00, 3'd1, 2'b10, 32'hFFFF_1234, 32'hBEEF_1234);
    t_write("R2 seq word", 8'h00, 3'd2, 2'b11, 32'hCAFE_F00D, 32'hCAFE_F00D);
    t_read(32'hCAFE_F00D);
    t_ignored("R5 idle", 1'b1, 2'b00, 1'b0);
    t_ignored("R5 busy", 1'b1, 2'b01, 1'b0);
    t_ignored("R6 unselected", 1'b0, 2'b10, 1'b0);
    t_ignored("R6 hready low", 1'b1, 2'b10, 1'b1);
    t_error("R8 offset", 8'h04, 3'd2);
    t_error("R8 high offset", 8'h80, 3'd0);
    t_error("R9 size", 8'h00, 3'd3);
    t_error("R9 misaligned half", 8'h01, 3'd1);
    t_error("R9 misaligned word", 8'h02, 3'd2);
    t_write("R2 after errors", 8'h00, 3'd2, 2'b10, 32'h0F0F_0F0F, 32'h0F0F_0F0F);
    chk("R11 tracks valid writes", led_n, 32'h0F0F_0F0F);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule